// File: doc/BRIEF.md
# Three-Level PWM Command Decoder

This block turns a three-level pulse-width input into a gate command for the switch sequencer of a synchronous buck stage. Two comparator outputs describe where the input voltage sits: one is set when the input is above the upper threshold, the other when it is below the lower threshold. A high level asks for the high-side switch, a low level asks for the low-side switch. A level in the window between the thresholds asks for both switches to turn off.

A window level counts as a shutoff request only after it has persisted for a hold-off time, given as a number of clock cycles. Until that time runs out, the decoder keeps issuing the last valid low or high command. When the input leaves the window, the new command follows at once, with no hold-off on the exit path. The comparator bits are asynchronous to the clock and pass through a synchronizer first. The command therefore changes SYNC_STAGES + 1 clock edges after the first edge that samples a new input value.

Top module: `pwm3_level_decoder`

## Requirements
- R1: With the upper comparator set and the lower clear, drive_cmd_o becomes 2'b10 (bit 1 = high-side on) SYNC_STAGES+1 clock edges after the first edge that samples the input.
- R2: With the lower comparator set and the upper clear, drive_cmd_o becomes 2'b01 (bit 0 = low-side on), with the same latency as R1.
- R3: Once the input has been classified as window level for HOLD_CYCLES consecutive cycles, drive_cmd_o becomes 2'b00 (both off) and stays 2'b00 while the input remains in the window.
- R4: During a window run shorter than HOLD_CYCLES, drive_cmd_o keeps the last valid command.
- R5: The hold-off count restarts whenever the input leaves the window. Window runs separated by one valid sample never add up to a shutoff.
- R6: Leaving the both-off state to a high or low level produces 2'b10 or 2'b01 with the same latency as R1, with no hold-off applied.
- R7: Both comparator bits set at once counts as window level. It shares the hold-off count with the both-clear pattern.
- R8: While reset is asserted, drive_cmd_o is 2'b00, whatever it showed before.
- R9: drive_cmd_o never has both bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| above_hi_i | input | 1 | Comparator: input above the upper threshold (asynchronous) |
| below_lo_i | input | 1 | Comparator: input below the lower threshold (asynchronous) |
| drive_cmd_o | output | 2 | Gate command: 2'b10 high-side on, 2'b01 low-side on, 2'b00 both off |

## Verification
Steady high and low stretches set the basic mapping and the latency. Window runs one cycle shorter than the hold-off separate "keep last command" from "shut off early". A run of exactly the hold-off length pins down the cycle in which the shutoff lands. Window runs split by a single valid sample would shut the stage off only if the count failed to restart. Runs that mix the both-clear and both-set patterns show that the two patterns count together. A single-cycle exit from both-off to high or low shows whether any hold-off leaks onto the exit path.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  // Classified input level
  typedef enum logic [1:0] {
    LVL_MID  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;

  // Gate command: bit 1 high-side on, bit 0 low-side on
  typedef enum logic [1:0] {
    CMD_OFF = 2'b00,
    CMD_LS  = 2'b01,
    CMD_HS  = 2'b10
  } cmd_e;

endpackage

// File: rtl/pwm3_rst_sync.sv
module pwm3_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwm3_bit_sync.sv
module pwm3_bit_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_i;
      end else begin : g_rest
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwm3_classify.sv
module pwm3_classify
  import pwm3_pkg::*;
(
  input  logic above_i,
  input  logic below_i,
  output lvl_e lvl_o
);
  always_comb begin
    unique case ({above_i, below_i})
      2'b10:   lvl_o = LVL_HIGH;
      2'b01:   lvl_o = LVL_LOW;
      default: lvl_o = LVL_MID;   // both clear or both set: window (R7)
    endcase
  end
endmodule

// File: rtl/pwm3_holdoff_timer.sv
module pwm3_holdoff_timer
  import pwm3_pkg::*;
#(
  parameter int HOLD_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  lvl_e lvl_i,
  output logic done_o
);
  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             in_win;
  logic             sat;

  always_comb begin
    in_win = (lvl_i == LVL_MID);
    sat    = (cnt_q == LIMIT);
    cnt_en = !in_win || !sat;
    if (!in_win) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(1);
    done_o = in_win && sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i != LVL_MID) |=> (cnt_q == '0)); // R5

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= LIMIT)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !sat) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R3
endmodule

// File: rtl/pwm3_cmd_reg.sv
module pwm3_cmd_reg
  import pwm3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_e lvl_i,
  input  logic hold_done_i,
  output cmd_e cmd_o
);
  cmd_e cmd_q;
  cmd_e cmd_d;

  always_comb begin
    unique case (lvl_i)
      LVL_HIGH: cmd_d = CMD_HS;
      LVL_LOW:  cmd_d = CMD_LS;
      default:  cmd_d = hold_done_i ? CMD_OFF : cmd_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= CMD_OFF;
    else        cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;

  AST_HIGH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i == LVL_HIGH) |=> (cmd_q == CMD_HS)); // R1

  AST_LOW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i == LVL_LOW) |=> (cmd_q == CMD_LS)); // R2

  AST_OFF_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i == LVL_MID && hold_done_i) |=> (cmd_q == CMD_OFF)); // R3

  AST_KEEP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i == LVL_MID && !hold_done_i) |=> $stable(cmd_q)); // R4

  AST_NO_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_q)); // R9
endmodule

// File: rtl/pwm3_level_decoder.sv
module pwm3_level_decoder
  import pwm3_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       above_hi_i,
  input  logic       below_lo_i,
  output logic [1:0] drive_cmd_o
);
  logic       rst_sync_n;
  logic [1:0] cmp_sync;
  lvl_e       lvl;
  logic       hold_done;
  cmd_e       cmd;

  pwm3_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm3_bit_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_cmp_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({above_hi_i, below_lo_i}),
    .q_o   (cmp_sync)
  );

  pwm3_classify u_classify (
    .above_i (cmp_sync[1]),
    .below_i (cmp_sync[0]),
    .lvl_o   (lvl)
  );

  pwm3_holdoff_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (lvl),
    .done_o (hold_done)
  );

  pwm3_cmd_reg u_cmd (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .lvl_i       (lvl),
    .hold_done_i (hold_done),
    .cmd_o       (cmd)
  );

  assign drive_cmd_o = cmd;

  AST_RESET_OFF: assert property (@(posedge clk)
    (!rst_sync_n) |-> (drive_cmd_o == 2'b00)); // R8
endmodule

// File: tb/pwm3_level_decoder_bench.sv
module pwm3_level_decoder_bench;
  localparam int SYNC = 2;
  localparam int HOLD = 12;
  localparam int LAT  = SYNC + 1;

  logic       clk;
  logic       rst_n;
  logic       above;
  logic       below;
  logic [1:0] cmd;

  int checks;
  int fails;
  int pcnt;
  bit run;

  logic [1:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] m_last;
  int         m_run;

  pwm3_level_decoder #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) u_pwm3_level_decoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .above_hi_i  (above),
    .below_lo_i  (below),
    .drive_cmd_o (cmd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: drive_cmd_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one comparator pair per cycle and pushes the expected command
  task automatic drive(input logic hi, input logic lo, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [1:0] e;
      @(negedge clk);
      above = hi;
      below = lo;
      if (hi && !lo) begin
        e = 2'b10; m_run = 0;
      end else if (lo && !hi) begin
        e = 2'b01; m_run = 0;
      end else begin
        m_run++;
        e = (m_run >= HOLD) ? 2'b00 : m_last;
      end
      m_last = e;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      run = 1'b1;
    end
  endtask

  // Monitor: compares the design output against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (run) begin
        pcnt++;
        if (pcnt >= LAT && exp_q.size() > 0) begin
          logic [1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cmd, e, t);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; pcnt = 0; run = 1'b0;
    m_last = 2'b00; m_run = 0;
    rst_n = 1'b0; above = 1'b0; below = 1'b1;
    #12;
    check(cmd, 2'b00, "R8 reset state");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    drive(1'b0, 1'b1, 4, "R2 low level");
    drive(1'b1, 1'b0, 4, "R1 high level");
    drive(1'b0, 1'b0, HOLD - 1, "R4 short window keeps high");
    drive(1'b1, 1'b0, 1, "R1 high between windows");
    drive(1'b0, 1'b0, HOLD - 1, "R5 window run A");
    drive(1'b0, 1'b1, 1, "R5 one valid low sample");
    drive(1'b0, 1'b0, HOLD - 1, "R5 window run B");
    drive(1'b0, 1'b0, 1, "R3 hold-off expires");
    drive(1'b0, 1'b0, 3, "R3 stays off");
    drive(1'b1, 1'b0, 1, "R6 exit to high");
    drive(1'b1, 1'b0, 2, "R1 high");
    drive(1'b1, 1'b1, HOLD, "R7 both set shuts off");
    drive(1'b0, 1'b1, 1, "R6 exit to low");
    drive(1'b0, 1'b1, 2, "R2 low");
    drive(1'b1, 1'b1, HOLD / 2, "R7 mixed run part one");
    drive(1'b0, 1'b0, HOLD - HOLD / 2, "R7 mixed run part two");
    drive(1'b0, 1'b1, LAT + 1, "R2 flush");
    @(negedge clk);
    run = 1'b0;

    above = 1'b1; below = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    check(cmd, 2'b10, "R1 before reset");
    rst_n = 1'b0;
    #1;
    check(cmd, 2'b00, "R8 reset clears command");
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule